// File: doc/BRIEF.md
# Pulse-distance infrared frame transmitter

The block turns one parallel request into one complete infrared remote-control frame on a single line. The line is the demodulated, active-low form: a low level stands for a carrier burst, a high level for silence. A frame opens with a long low leader and a shorter high gap. Then come 32 payload bits, each coded by the length of the high space after a fixed low burst. The frame ends with one closing burst. The payload is the 16-bit address, the 8 data bits and their bitwise complement. The block forms the complement itself.

A client presents an address and a data byte and strobes start while the block is idle. The block latches both values and raises busy. It then times every phase with a single cycle counter. All phase lengths are derived at elaboration time from the clock frequency parameter, so the same code serves any system clock. When the closing burst ends, the line returns high, busy drops and a one-cycle done pulse marks the end of the frame.

Top module: `nec_tx`

## Requirements
- R1: While reset is asserted and after it is released with no request, ir_o is high (1), busy_o is 0 and done_o is 0.
- R2: A frame begins with ir_o low for the 9000 us count and then high for the 4500 us count.
- R3: Every payload bit begins with ir_o low for the 560 us count; for a logic 0 the following high space lasts the 560 us count.
- R4: For a logic 1 the high space after the bit burst lasts the 1690 us count.
- R5: Payload bit k (k = 0..31) is bit k of the word {~data_i, data_i, addr_i}: address bits 0..15 first, then data bits 0..7, then inverted data bits 0..7, each field least significant bit first.
- R6: After the 32nd space, ir_o is driven low for the 560 us count and then returns high.
- R7: A count for a duration of D microseconds is floor(CLK_HZ * D / 1000000) clock cycles. Each phase lasts exactly that many cycles.
- R8: start_i is accepted only while busy_o is 0. addr_i and data_i are captured in the accepting cycle, and later changes to them do not alter the frame in progress.
- R9: A start_i pulse while busy_o is 1 is ignored: the frame in progress keeps its timing, and no second frame follows it.
- R10: busy_o is 1 from the cycle after acceptance until the cycle in which ir_o returns high after the closing burst. In that cycle done_o is 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame request strobe |
| addr_i | input | 16 | Address to send |
| data_i | input | 8 | Data byte to send |
| ir_o | output | 1 | Demodulated IR line, idles high |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse when the line returns to idle |

## Verification
The bench sends four frames, and each frame tells apart a different kind of fault. The frame with address 0x0001 and data 0xAA has alternating data bits, which exposes a swapped field order or a reversed bit order. The frame with all-ones address and zero data has long runs of one value, which exposes a wrong space length for either bit value. The frame with zero address and data 0xFF pits the complement against the plain data. During one frame, start is pulsed and the inputs are changed, which shows whether latching and the busy guard hold. Every frame is compared cycle by cycle against a level sequence the bench builds from the requirements. Each frame is also measured interval by interval and decoded back into address, data and complement.

// File: rtl/nec_tx_pkg.sv
package nec_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEAD_LO,
    PH_LEAD_HI,
    PH_BIT_LO,
    PH_BIT_HI,
    PH_TAIL_LO
  } phase_e;

  // Microsecond duration to clock cycles, truncated.
  function automatic int unsigned us_to_cycles(input longint unsigned hz,
                                               input longint unsigned us);
    return int'((hz * us) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/nec_tx_timer.sv
module nec_tx_timer #(
  parameter int unsigned W = 19
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  // R7: an expired timer stays at zero until reloaded
  p_no_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/nec_tx_shifter.sv
module nec_tx_shifter #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              bit_o,
  output logic              last_o
);

  localparam int unsigned IDX_W = $clog2(WORD_W);

  logic [WORD_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= word_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= sr_q >> 1;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign bit_o  = sr_q[0];
  assign last_o = (idx_q == IDX_W'(WORD_W - 1));

  // R5: no shift past the final payload bit
  p_idx_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> !shift_i);

endmodule

// File: rtl/nec_tx.sv
module nec_tx
  import nec_tx_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ir_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int unsigned WORD_W  = ADDR_W + 2 * DATA_W;
  localparam int unsigned N_LEADL = us_to_cycles(CLK_HZ, 9000);
  localparam int unsigned N_LEADH = us_to_cycles(CLK_HZ, 4500);
  localparam int unsigned N_BURST = us_to_cycles(CLK_HZ, 560);
  localparam int unsigned N_ONE   = us_to_cycles(CLK_HZ, 1690);
  localparam int unsigned CNT_W   = $clog2(N_LEADL + 1);

  phase_e           ph_q, ph_d;
  logic             ir_q, done_q;
  logic             load, shift, expire, cur_bit, last_bit, accept;
  logic [CNT_W-1:0] len;

  assign accept = (ph_q == PH_IDLE) && start_i;

  always_comb begin
    ph_d  = ph_q;
    load  = 1'b0;
    shift = 1'b0;
    len   = '0;
    unique case (ph_q)
      PH_IDLE: if (start_i) begin
        ph_d = PH_LEAD_LO; load = 1'b1; len = CNT_W'(N_LEADL - 1);
      end
      PH_LEAD_LO: if (expire) begin
        ph_d = PH_LEAD_HI; load = 1'b1; len = CNT_W'(N_LEADH - 1);
      end
      PH_LEAD_HI: if (expire) begin
        ph_d = PH_BIT_LO; load = 1'b1; len = CNT_W'(N_BURST - 1);
      end
      PH_BIT_LO: if (expire) begin
        ph_d = PH_BIT_HI; load = 1'b1;
        len  = cur_bit ? CNT_W'(N_ONE - 1) : CNT_W'(N_BURST - 1);
      end
      PH_BIT_HI: if (expire) begin
        load = 1'b1; len = CNT_W'(N_BURST - 1);
        if (last_bit) ph_d = PH_TAIL_LO;
        else begin
          ph_d = PH_BIT_LO; shift = 1'b1;
        end
      end
      PH_TAIL_LO: if (expire) ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      ir_q   <= 1'b1;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      ir_q   <= !(ph_d == PH_LEAD_LO || ph_d == PH_BIT_LO || ph_d == PH_TAIL_LO);
      done_q <= (ph_q == PH_TAIL_LO) && (ph_d == PH_IDLE);
    end
  end

  nec_tx_timer #(.W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .len_i    (len),
    .expire_o (expire)
  );

  nec_tx_shifter #(.WORD_W(WORD_W)) u_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (accept),
    .shift_i (shift),
    .word_i  ({~data_i, data_i, addr_i}),
    .bit_o   (cur_bit),
    .last_o  (last_bit)
  );

  assign ir_o   = ir_q;
  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = done_q;

  // R1: line is high whenever no frame is in progress
  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> ir_o);

  // R10: done lasts one cycle
  p_done_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10: done coincides with the end of busy
  p_done_ends_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9: while busy, start never reloads the leader
  p_busy_ignores_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && ph_q != PH_TAIL_LO) |=> busy_o);

endmodule

// File: tb/nec_tx_tb.sv
module nec_tx_tb;

  localparam int unsigned CLK_HZ   = 100_000;
  localparam time         CLK_PER  = 10ns;
  localparam int          T_LEADL  = int'((64'(CLK_HZ) * 9000) / 1_000_000);
  localparam int          T_LEADH  = int'((64'(CLK_HZ) * 4500) / 1_000_000);
  localparam int          T_BURST  = int'((64'(CLK_HZ) * 560) / 1_000_000);
  localparam int          T_ONE    = int'((64'(CLK_HZ) * 1690) / 1_000_000);
  localparam int          WDOG_MAX = 150_000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        ir, busy, done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #(CLK_PER / 2) clk = ~clk;

  nec_tx #(.CLK_HZ(CLK_HZ)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .start_i (start),
    .addr_i  (addr),
    .data_i  (data),
    .ir_o    (ir),
    .busy_o  (busy),
    .done_o  (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG_MAX) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG_MAX);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // Sends one frame; optionally disturbs inputs and pulses start mid-frame.
  task automatic send_frame(input logic [15:0] a, input logic [7:0] d, input bit disturb);
    bit        exp_q[$];
    int        runs[$];
    bit        run_lvl;
    int        run_len;
    int        wave_err = 0, busy_err = 0, done_err = 0;
    logic [31:0] word, rx;
    word = {~d, d, a};
    for (int i = 0; i < T_LEADL; i++) exp_q.push_back(1'b0);
    for (int i = 0; i < T_LEADH; i++) exp_q.push_back(1'b1);
    for (int b = 0; b < 32; b++) begin
      for (int i = 0; i < T_BURST; i++) exp_q.push_back(1'b0);
      for (int i = 0; i < (word[b] ? T_ONE : T_BURST); i++) exp_q.push_back(1'b1);
    end
    for (int i = 0; i < T_BURST; i++) exp_q.push_back(1'b0);

    @(negedge clk);
    addr = a; data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    run_lvl = 1'b0; run_len = 0;
    for (int c = 0; c < exp_q.size(); c++) begin
      if (ir !== exp_q[c]) wave_err++;
      if (busy !== 1'b1) busy_err++;
      if (done !== 1'b0) done_err++;
      if (ir === run_lvl) run_len++;
      else begin
        runs.push_back(run_len); run_lvl = ir; run_len = 1;
      end
      if (disturb && c == 300)  begin addr = ~a; data = ~d; end  // R8
      if (disturb && c == 1500) start = 1'b1;                    // R9
      if (disturb && c == 1501) start = 1'b0;
      @(negedge clk);
    end
    runs.push_back(run_len);

    check(wave_err == 0, "R2-frame", "cycle mismatches", wave_err, 0);
    check(busy_err == 0, "R10", "busy low inside frame", busy_err, 0);
    check(done_err == 0, "R10", "early done", done_err, 0);
    check(ir === 1'b1 && busy === 1'b0, "R6", "line high and idle after tail", ir, 1);
    check(done === 1'b1, "R10", "done at line return", done, 1);
    @(negedge clk);
    check(done === 1'b0, "R10", "done width", done, 0);

    // interval measurement and decode
    check(runs.size() == 67, "R5", "interval count", runs.size(), 67);
    if (runs.size() == 67) begin
      check(runs[0] >= T_LEADL - 1 && runs[0] <= T_LEADL + 1, "R2", "leader low", runs[0], T_LEADL);
      check(runs[1] >= T_LEADH - 1 && runs[1] <= T_LEADH + 1, "R2", "leader high", runs[1], T_LEADH);
      rx = '0;
      for (int b = 0; b < 32; b++) begin
        int lo = runs[2 + 2 * b];
        int hi = runs[3 + 2 * b];
        check(lo >= T_BURST - 1 && lo <= T_BURST + 1, "R3", "bit burst", lo, T_BURST);
        rx[b] = (hi > (T_BURST + T_ONE) / 2);
        if (rx[b]) check(hi >= T_ONE - 1 && hi <= T_ONE + 1, "R4", "one space", hi, T_ONE);
        else       check(hi >= T_BURST - 1 && hi <= T_BURST + 1, "R3", "zero space", hi, T_BURST);
      end
      check(runs[66] >= T_BURST - 1 && runs[66] <= T_BURST + 1, "R6", "tail burst", runs[66], T_BURST);
      check(rx[15:0] == a, "R5", "address", rx[15:0], a);
      check(rx[23:16] == d, "R5", "data", rx[23:16], d);
      check(rx[31:24] == ~d, "R5", "complement", rx[31:24], ~d);
      if (disturb) check(rx == word, "R8", "latched word", rx, word);
    end

    // R9: no further frame after a stray start
    begin
      int lows = 0;
      for (int i = 0; i < 50; i++) begin
        if (ir !== 1'b1 || busy !== 1'b0) lows++;
        @(negedge clk);
      end
      check(lows == 0, "R9", "line stays idle after frame", lows, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ir === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "during reset", {ir, busy, done}, 3'b100);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(ir === 1'b1 && busy === 1'b0 && done === 1'b0, "R1", "after reset", {ir, busy, done}, 3'b100);
    check(T_LEADL == 900 && T_ONE == 169, "R7", "derived counts", T_LEADL, 900);

    send_frame(16'h0001, 8'hAA, 1'b0);
    send_frame(16'hFFFF, 8'h00, 1'b0);
    send_frame(16'h1234, 8'h5C, 1'b1);
    send_frame(16'h0000, 8'hFF, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule